// File: doc/BRIEF.md
# Register-Programmed Clock Rate Divider

This block divides one input clock by an integer taken from a field of a control register. Software writes the register through a simple write port and reads it back through a read port. A two-bit encoding selector in the same register says how the field becomes a divisor. The choices are field plus one, the field itself, two to the power of the field, or an entry of a parameter table in which zero entries mark unusable codes. Outside table mode, a divisor below the minimum or above the maximum parameter is rejected.

A write that decodes to an unusable divisor is dropped as a whole, and a sticky error output is raised. A valid write can be held back: when its hold bit is set and its commit bit is clear, the new field is stored and readable but the divider keeps running at its old rate until a write with the commit bit arrives. A new divisor is taken up only when the running output period ends, so the output never shows a shortened pulse. The output is never gated. With divide-by-one it is the input clock itself.

Top module: `clk_rate_div`

## Requirements
- R1: With encoding 0 in bits [9:8], the divisor is the code in bits [3:0] plus one, so all 16 codes (divisors 1 to 16) are accepted.
- R2: With encoding 1, the divisor equals the code; code 0 is below the minimum divisor of 1 and is rejected.
- R3: With encoding 2, the divisor is 2 to the power of the code; codes 0 to 5 (divisors 1 to 32) are accepted and codes 6 to 15 exceed the maximum of 40 and are rejected.
- R4: With encoding 3, the divisor is table entry [code] of {4,8,0,16,1,0,6,3,2,0,5,7,12,0,9,10} (code 0 first), with no min/max bound; codes whose entry is 0 (2, 5, 9, 13) are rejected.
- R5: Read data is the stored code at bits [3:0], the encoding at [9:8], the stored hold bit at [10], the pending flag at [11], and zero elsewhere, updated in the cycle after a valid write.
- R6: A rejected write changes neither the read data nor the divisor in use, and it sets bad_code, which stays high until reset.
- R7: A valid write with hold bit 10 set and commit bit 11 clear stores the field and sets the pending flag but leaves the divisor unchanged. A valid write with bit 11 set, or with bit 10 clear, applies its divisor and clears the pending flag.
- R8: A new divisor takes effect only after the period in progress has completed its full length.
- R9: With divisor 1, clk_out equals clk. With divisor N of 2 or more, clk_out is high for the first floor(N/2) input cycles of each N-cycle period and low for the rest.
- R10: Reset gives read data 0, bad_code 0, no pending update and divisor 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Value written to the control register |
| rd_data | output | 32 | Control register read-back with pending flag |
| clk_out | output | 1 | Divided clock |
| bad_code | output | 1 | Sticky flag: a write carried an unusable code |

## Verification
All 64 pairs of encoding and code are written in turn. After each write the output waveform is measured over a full period, and the read-back is compared. This separates the four encodings, checks the accepted/rejected boundary of each one, and shows whether a rejected write left the previous rate running. A rate change is issued in the first cycle of a 6-cycle period to show that the old period runs out in full before the 4-cycle pattern begins. A hold, commit and immediate-write sequence shows that held fields reach the readout but not the output until they are committed.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    ENC_PLUS1  = 2'd0,
    ENC_DIRECT = 2'd1,
    ENC_POW2   = 2'd2,
    ENC_TABLE  = 2'd3
  } enc_mode_e;

  // Two to the power e, saturated to all ones when it would not fit.
  function automatic logic [31:0] pow2_sat(input logic [31:0] e);
    if (e > 32'd30) return '1;
    return 32'd1 << e;
  endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 40,
  parameter logic [(1<<FIELD_W)*DIV_W-1:0] TABLE = '0
) (
  input  enc_mode_e          mode,
  input  logic [FIELD_W-1:0] code,
  output logic               ok,
  output logic [DIV_W-1:0]   div
);
  localparam int TBL_N = 1 << FIELD_W;

  logic [DIV_W-1:0] tbl [TBL_N];
  logic [31:0]      wide;

  for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
    assign tbl[i] = TABLE[i*DIV_W +: DIV_W];
  end

  always_comb begin
    unique case (mode)
      ENC_PLUS1:  wide = 32'(code) + 32'd1;
      ENC_DIRECT: wide = 32'(code);
      ENC_POW2:   wide = pow2_sat(32'(code));
      default:    wide = 32'(tbl[code]);
    endcase
    if (mode == ENC_TABLE) ok = (wide != 32'd0);
    else ok = (wide >= 32'(MIN_DIV)) && (wide <= 32'(MAX_DIV));
    div = wide[DIV_W-1:0];
  end
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int FIELD_LSB  = 0,
  parameter int FIELD_W    = 4,
  parameter int MODE_LSB   = 8,
  parameter int HOLD_BIT   = 10,
  parameter int COMMIT_BIT = 11,
  parameter int DIV_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic               wr_bad,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [DIV_W-1:0]   new_div,
  output logic [DIV_W-1:0]   tgt_div,
  output logic               pend,
  output logic               err,
  output logic [REG_W-1:0]   rd_data
);
  logic [FIELD_W-1:0] code_q;
  enc_mode_e          mode_q;
  logic               hold_q;
  logic               w_hold, w_commit;

  assign w_hold   = wr_data[HOLD_BIT];
  assign w_commit = wr_data[COMMIT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      mode_q  <= ENC_PLUS1;
      hold_q  <= 1'b0;
      tgt_div <= DIV_W'(1);
      pend    <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (wr_ok) begin
        code_q <= wr_data[FIELD_LSB +: FIELD_W];
        mode_q <= enc_mode_e'(wr_data[MODE_LSB +: 2]);
        hold_q <= w_hold;
        if (!w_hold || w_commit) begin
          tgt_div <= new_div;
          pend    <= 1'b0;
        end else begin
          pend <= 1'b1;
        end
      end
      if (wr_bad) err <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[FIELD_LSB +: FIELD_W] = code_q;
    rd_data[MODE_LSB +: 2]        = mode_q;
    rd_data[HOLD_BIT]             = hold_q;
    rd_data[COMMIT_BIT]           = pend;
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tgt_div,
  output logic [DIV_W-1:0] cur_div,
  output logic [DIV_W-1:0] cnt,
  output logic             period_end,
  output logic             clk_out
);
  logic [DIV_W-1:0] nxt_cnt, nxt_div;
  logic             hi_q;

  assign period_end = (cnt == cur_div - DIV_W'(1));

  always_comb begin
    if (period_end) begin
      nxt_cnt = '0;
      nxt_div = tgt_div;
    end else begin
      nxt_cnt = cnt + DIV_W'(1);
      nxt_div = cur_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_div <= DIV_W'(1);
      hi_q    <= 1'b0;
    end else begin
      cnt     <= nxt_cnt;
      cur_div <= nxt_div;
      hi_q    <= (nxt_cnt < (nxt_div >> 1));
    end
  end

  // Divide-by-one passes the input clock straight through.
  assign clk_out = (cur_div == DIV_W'(1)) ? clk : hi_q;
endmodule

// File: rtl/clk_rate_div.sv
module clk_rate_div
  import clkdiv_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int FIELD_LSB  = 0,
  parameter int FIELD_W    = 4,
  parameter int MODE_LSB   = 8,
  parameter int HOLD_BIT   = 10,
  parameter int COMMIT_BIT = 11,
  parameter int DIV_W      = 8,
  parameter int MIN_DIV    = 1,
  parameter int MAX_DIV    = 40,
  parameter logic [(1<<FIELD_W)*DIV_W-1:0] TABLE =
    128'h0a09000c_07050002_03060001_10000804
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out,
  output logic             bad_code
);
  logic               code_ok;
  logic [DIV_W-1:0]   dec_div;
  logic               wr_ok, wr_bad;
  logic               wr_hold, wr_commit;
  logic [DIV_W-1:0]   tgt_div, cur_div, cnt_q;
  logic               period_end, pend;

  assign wr_ok     = wr_en && code_ok;
  assign wr_bad    = wr_en && !code_ok;
  assign wr_hold   = wr_data[HOLD_BIT];
  assign wr_commit = wr_data[COMMIT_BIT];

  clkdiv_decode #(
    .FIELD_W(FIELD_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV),
    .MAX_DIV(MAX_DIV), .TABLE(TABLE)
  ) u_dec (
    .mode (enc_mode_e'(wr_data[MODE_LSB +: 2])),
    .code (wr_data[FIELD_LSB +: FIELD_W]),
    .ok   (code_ok),
    .div  (dec_div)
  );

  clkdiv_ctrl #(
    .REG_W(REG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W),
    .MODE_LSB(MODE_LSB), .HOLD_BIT(HOLD_BIT), .COMMIT_BIT(COMMIT_BIT),
    .DIV_W(DIV_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (wr_ok),
    .wr_bad  (wr_bad),
    .wr_data (wr_data),
    .new_div (dec_div),
    .tgt_div (tgt_div),
    .pend    (pend),
    .err     (bad_code),
    .rd_data (rd_data)
  );

  clkdiv_core #(.DIV_W(DIV_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgt_div    (tgt_div),
    .cur_div    (cur_div),
    .cnt        (cnt_q),
    .period_end (period_end),
    .clk_out    (clk_out)
  );
endmodule

// File: rtl/clk_rate_div_chk.sv
module clk_rate_div_chk #(
  parameter int REG_W = 32,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ok,
  input logic             wr_bad,
  input logic             wr_hold,
  input logic             wr_commit,
  input logic             period_end,
  input logic [DIV_W-1:0] cur_div,
  input logic [DIV_W-1:0] cnt_q,
  input logic [REG_W-1:0] rd_data,
  input logic             pend,
  input logic             bad_code
);
  a_r8_div_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(cur_div));

  a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cur_div);

  a_r6_reject_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> $stable(rd_data));

  a_r6_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> bad_code);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> bad_code);

  a_r7_hold_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_hold && !wr_commit) |=> pend);

  a_r7_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (!wr_hold || wr_commit)) |=> !pend);
endmodule

bind clk_rate_div clk_rate_div_chk #(.REG_W(REG_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ok      (wr_ok),
  .wr_bad     (wr_bad),
  .wr_hold    (wr_hold),
  .wr_commit  (wr_commit),
  .period_end (period_end),
  .cur_div    (cur_div),
  .cnt_q      (cnt_q),
  .rd_data    (rd_data),
  .pend       (pend),
  .bad_code   (bad_code)
);

// File: tb/tb_clk_rate_div.sv
module tb_clk_rate_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_out;
  logic        bad_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int tbl [16] = '{4, 8, 0, 16, 1, 0, 6, 3, 2, 0, 5, 7, 12, 0, 9, 10};
  string mode_req [4] = '{"R1", "R2", "R3", "R4"};

  always #2 clk = ~clk;

  clk_rate_div dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_out(clk_out), .bad_code(bad_code)
  );

  task automatic check(input bit good, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [31:0] v);
    wr_data = v;
    wr_en   = 1'b1;
    tick();
    wr_en   = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int mode, input int code,
                                      input bit hold, input bit commit);
    return 32'(code) | (32'(mode) << 8) | (32'(hold) << 10) | (32'(commit) << 11);
  endfunction

  // Expected divisor and acceptance for one encoding and code.
  function automatic void model(input int mode, input int code,
                                output bit ok, output int d);
    case (mode)
      0: d = code + 1;
      1: d = code;
      2: d = 2 ** code;
      default: d = tbl[code];
    endcase
    ok = (mode == 3) ? (d != 0) : (d >= 1 && d <= 40);
  endfunction

  // Let any change settle, then compare one full output period with n.
  task automatic measure(input int n, input string req, input string what);
    bit good = 1;
    int bad_idx = -1;
    bit prev;
    bit found = 0;
    repeat (90) tick();
    if (n == 1) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge clk); #1;
        if (clk_out !== 1'b1) good = 0;
        @(negedge clk); #1;
        if (clk_out !== 1'b0) good = 0;
      end
    end else begin
      prev = clk_out;
      for (int k = 0; k < 200 && !found; k++) begin
        tick();
        if (!prev && clk_out) found = 1;
        prev = clk_out;
      end
      if (!found) begin
        good = 0;
      end else begin
        for (int i = 1; i < n; i++) begin
          tick();
          if (clk_out !== ((i < n / 2) ? 1'b1 : 1'b0)) begin
            good = 0;
            if (bad_idx < 0) bad_idx = i;
          end
        end
        tick();
        if (clk_out !== 1'b1) begin
          good = 0;
          if (bad_idx < 0) bad_idx = n;
        end
      end
    end
    check(good, req, {what, " period pattern (first bad index as actual, divisor as expected)"},
          bad_idx, n);
  endtask

  initial begin
    bit ok;
    int d;
    int cur_n;
    logic [31:0] exp_reg;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10: reset state
    check(rd_data == 32'd0, "R10", "read data after reset", rd_data, 0);
    check(bad_code == 1'b0, "R10", "bad_code after reset", bad_code, 0);
    measure(1, "R10", "divide-by-1 after reset (R9)");

    cur_n = 1;
    exp_reg = '0;
    // R1..R4 sweep, with R5 readback and R6 rejection
    for (int mode = 0; mode < 4; mode++) begin
      for (int code = 0; code < 16; code++) begin
        model(mode, code, ok, d);
        do_write(ctl(mode, code, 0, 0));
        if (ok) begin
          exp_reg = ctl(mode, code, 0, 0);
          cur_n = d;
          check(rd_data == exp_reg, "R5", "readback after valid write", rd_data, exp_reg);
        end else begin
          check(rd_data == exp_reg, "R6", "readback kept after rejected write", rd_data, exp_reg);
          check(bad_code == 1'b1, "R6", "bad_code after rejected write", bad_code, 1);
        end
        measure(cur_n, mode_req[mode], ok ? "accepted code" : "rejected code keeps old rate");
      end
    end

    // R8: change requested in first cycle of a 6-cycle period
    begin
      bit prev;
      bit found = 0;
      bit good = 1;
      int bad_idx = -1;
      do_write(ctl(0, 5, 0, 0));
      repeat (90) tick();
      prev = clk_out;
      for (int k = 0; k < 200 && !found; k++) begin
        tick();
        if (!prev && clk_out) found = 1;
        prev = clk_out;
      end
      do_write(ctl(0, 3, 0, 0));
      for (int i = 1; i < 6; i++) begin
        if (i > 1) tick();
        if (clk_out !== ((i < 3) ? 1'b1 : 1'b0)) begin good = 0; if (bad_idx < 0) bad_idx = i; end
      end
      for (int j = 0; j < 4; j++) begin
        tick();
        if (clk_out !== ((j < 2) ? 1'b1 : 1'b0)) begin good = 0; if (bad_idx < 0) bad_idx = 10 + j; end
      end
      tick();
      if (clk_out !== 1'b1) begin good = 0; if (bad_idx < 0) bad_idx = 14; end
      check(found && good, "R8", "old 6-cycle period completes before 4-cycle pattern",
            bad_idx, -1);
    end

    // R7: held update, then commit, then immediate write
    do_write(ctl(0, 7, 1, 0));
    check(rd_data == (ctl(0, 7, 1, 0) | 32'h800), "R7", "held field readable with pending flag",
          rd_data, ctl(0, 7, 1, 0) | 32'h800);
    measure(4, "R7", "held write keeps divisor 4");
    do_write(ctl(0, 7, 1, 1));
    check(rd_data == ctl(0, 7, 1, 0), "R7", "commit clears pending flag",
          rd_data, ctl(0, 7, 1, 0));
    measure(8, "R7", "commit applies divisor 8");
    do_write(ctl(0, 2, 0, 0));
    measure(3, "R7", "write without hold applies divisor 3");

    // R10: second reset restores defaults and clears the error flag
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    check(rd_data == 32'd0, "R10", "read data after second reset", rd_data, 0);
    check(bad_code == 1'b0, "R10", "bad_code cleared by reset", bad_code, 0);
    measure(1, "R10", "divisor back to 1 (R9)");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule